// File: doc/BRIEF.md
# PWM Channel Enable and Period-Event Interrupt Registers

This block holds the shared control state of a small multi-channel pulse-width modulator. The channel counters and the clock divider sit elsewhere. Each channel has one bit in each of three registers: a run enable, an interrupt mask, and a pending flag. Software never writes the enable or mask words directly. It writes ones to a set strobe address or to a clear strobe address, so one driver can start or stop one channel without a read-modify-write that could race with another driver.

Each channel counter pulses an event input at the end of every period. Pulses from enabled channels are latched as pending. A read of the pending word returns the latched flags and clears them in the same cycle. The single interrupt line is high while any pending flag has its mask bit set. Addresses from 0x200 upward belong to the per-channel banks, which are outside this block, and read back as zero here.

Top module: `pwm_evt_ctl`

## Requirements
- R1: A write at offset 0x04 sets every enable bit whose data bit is 1 and leaves the bits written with 0 unchanged; the new value appears on `ch_enable` after the clock edge that takes the write.
- R2: A write at offset 0x08 clears every enable bit whose data bit is 1; a write of zero changes nothing.
- R3: A read at offset 0x0C returns the current enable word, with channel n in bit n.
- R4: Writes at offsets 0x10 and 0x14 set and clear interrupt mask bits by the same write-one rule; a read at offset 0x18 returns the mask word.
- R5: A read at offset 0x1C returns the pending word and clears every pending bit.
- R6: An event pulse on an enabled channel sets that channel's pending bit on the next clock edge.
- R7: An event pulse on a disabled channel leaves its pending bit unchanged.
- R8: An event that arrives in the same cycle as a pending read is not lost: it is absent from the value read and is pending after the read.
- R9: `irq` is high exactly when some channel is both pending and masked in; with a zero mask it stays low.
- R10: Reset clears all enable, mask and pending bits, and drives `irq` and `ch_enable` low.
- R11: Read data appears on `rdata`, with `rd_valid` high, one cycle after `rd_en`. Reads of any address that has no register (including 0x200 and above) return zero. Writes to read-only offsets change nothing.
- R12: Data bits at and above NUM_CH are ignored on writes and read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data, one bit per channel |
| ch_event | input | NUM_CH | Period-end pulse from each channel counter |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle that `rdata` holds a read result |
| ch_enable | output | NUM_CH | Run enable for each channel counter |
| irq | output | 1 | Interrupt request: pending AND mask, reduced by OR |

## Verification
The bench uses the defaults: four channels and a 12-bit address. With only four live channels, writes of all-ones words drive the 28 unused upper bits, which shows that they are dropped. The 12-bit address also reaches the per-channel bank region at 0x200, which must read as zero. The bench drives an event in the same cycle as a pending read, in a single case, so the acknowledge-versus-arrival race is tested directly.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Offsets of the global register window (software-visible layout).
  localparam int OFS_EN_SET = 'h04;
  localparam int OFS_EN_CLR = 'h08;
  localparam int OFS_EN_RD  = 'h0C;
  localparam int OFS_MK_SET = 'h10;
  localparam int OFS_MK_CLR = 'h14;
  localparam int OFS_MK_RD  = 'h18;
  localparam int OFS_PEND   = 'h1C;

  typedef enum logic [1:0] {RS_NONE, RS_EN, RS_MASK, RS_PEND} rsel_e;

  // Write-one-to-set / write-one-to-clear update.
  function automatic word_t w1_update(word_t q, word_t set_b, word_t clr_b);
    return (q | set_b) & ~clr_b;
  endfunction

  // Pending update: a read acknowledge drops the old flags, new events win.
  function automatic word_t pend_update(word_t q, word_t live, logic ack);
    return (ack ? '0 : q) | live;
  endfunction

  // Bits that carry a real channel.
  function automatic word_t chan_keep(int n);
    word_t m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/pwmc_regdec.sv
module pwmc_regdec
  import pwmc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              en_set_stb,
  output logic              en_clr_stb,
  output logic              mk_set_stb,
  output logic              mk_clr_stb,
  output logic              pend_ack,
  output rsel_e             rd_sel
);
  function automatic logic hit(logic [ADDR_W-1:0] a, int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    en_set_stb = wr_en && hit(addr, OFS_EN_SET);
    en_clr_stb = wr_en && hit(addr, OFS_EN_CLR);
    mk_set_stb = wr_en && hit(addr, OFS_MK_SET);
    mk_clr_stb = wr_en && hit(addr, OFS_MK_CLR);
    pend_ack   = rd_en && hit(addr, OFS_PEND);
    if (hit(addr, OFS_EN_RD))      rd_sel = RS_EN;
    else if (hit(addr, OFS_MK_RD)) rd_sel = RS_MASK;
    else if (hit(addr, OFS_PEND))  rd_sel = RS_PEND;
    else                           rd_sel = RS_NONE;
  end
endmodule

// File: rtl/pwmc_setclr_reg.sv
module pwmc_setclr_reg
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_stb,
  input  logic  clr_stb,
  input  word_t wdata,
  output word_t q
);
  localparam word_t KEEP = chan_keep(NUM_CH);

  word_t set_bits, clr_bits;
  assign set_bits = set_stb ? (wdata & KEEP) : '0;
  assign clr_bits = clr_stb ? (wdata & KEEP) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= w1_update(q, set_bits, clr_bits);

  // R1 / R4: ones written to the set strobe are 1 afterwards
  a_r1_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((q & $past(wdata & KEEP)) == $past(wdata & KEEP)));
  // R2 / R4: ones written to the clear strobe are 0 afterwards
  a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(wdata)) == '0));
  // R11: no strobe, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> (q == $past(q)));
  // R12: unused bits stay zero
  a_r12_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~KEEP) == '0);
endmodule

// File: rtl/pwmc_pending.sv
module pwmc_pending
  import pwmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t evt,
  input  word_t en,
  input  word_t mask,
  input  logic  ack,
  output word_t pend,
  output word_t evt_live,
  output logic  irq
);
  assign evt_live = evt & en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= pend_update(pend, evt_live, ack);

  assign irq = |(pend & mask);

  // R6: a live event is pending next cycle, acknowledge or not (R8)
  a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_live) |=> ((pend & $past(evt_live)) == $past(evt_live)));
  // R7: with no acknowledge, bits of disabled channels never rise
  a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((pend & ~$past(pend) & ~$past(en)) == '0));
  // R5: after an acknowledge only fresh events remain
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ((pend & ~$past(evt_live)) == '0));
  // R9: a zero mask keeps the line low
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/pwm_evt_ctl.sv
module pwm_evt_ctl
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [NUM_CH-1:0] ch_event,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic [NUM_CH-1:0] ch_enable,
  output logic              irq
);
  logic  en_set_stb, en_clr_stb, mk_set_stb, mk_clr_stb, pend_ack;
  rsel_e rd_sel;
  word_t en_q, mk_q, pend_q, evt_live, rd_mux;

  pwmc_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .en_set_stb(en_set_stb), .en_clr_stb(en_clr_stb),
    .mk_set_stb(mk_set_stb), .mk_clr_stb(mk_clr_stb),
    .pend_ack(pend_ack), .rd_sel(rd_sel));

  pwmc_setclr_reg #(.NUM_CH(NUM_CH)) u_en (
    .clk(clk), .rst_n(rst_n), .set_stb(en_set_stb), .clr_stb(en_clr_stb),
    .wdata(wdata), .q(en_q));

  pwmc_setclr_reg #(.NUM_CH(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_stb(mk_set_stb), .clr_stb(mk_clr_stb),
    .wdata(wdata), .q(mk_q));

  pwmc_pending u_pend (
    .clk(clk), .rst_n(rst_n), .evt(word_t'(ch_event)), .en(en_q),
    .mask(mk_q), .ack(pend_ack), .pend(pend_q), .evt_live(evt_live),
    .irq(irq));

  always_comb
    case (rd_sel)
      RS_EN:   rd_mux = en_q;
      RS_MASK: rd_mux = mk_q;
      RS_PEND: rd_mux = pend_q;
      default: rd_mux = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end

  assign ch_enable = en_q[NUM_CH-1:0];

  // R11: one-cycle read latency
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R5: a pending read returns the flags held at the read
  a_r5_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ack |=> (rdata == $past(pend_q)));
endmodule

// File: tb/test_pwm_evt_ctl.sv
module test_pwm_evt_ctl;
  localparam int NCH = 4;
  localparam logic [31:0] LIVE = 32'h0000_000F;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] ch_event = '0, ch_enable;
  logic rd_valid, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] en_m = '0, mk_m = '0, pend_m = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  pwm_evt_ctl i_pwm_evt_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ch_event(ch_event), .rdata(rdata), .rd_valid(rd_valid),
    .ch_enable(ch_enable), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pop the expected read word whenever a result is presented.
  always @(negedge clk)
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected rd_valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = 12'(a); wdata = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      'h04: en_m = en_m | (d & LIVE);
      'h08: en_m = en_m & ~d;
      'h10: mk_m = mk_m | (d & LIVE);
      'h14: mk_m = mk_m & ~d;
      default: ;
    endcase
  endtask

  // Driver: pushes the expected read word, optionally with events alongside.
  task automatic rd(int a, logic [NCH-1:0] ev, string tag);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1; addr = 12'(a); ch_event = ev;
    case (a)
      'h0C: e = en_m;
      'h18: e = mk_m;
      'h1C: e = pend_m;
      default: e = '0;
    endcase
    exp_q.push_back(e); tag_q.push_back(tag);
    if (a == 'h1C) pend_m = {28'd0, ev} & en_m;
    else           pend_m = pend_m | ({28'd0, ev} & en_m);
    @(negedge clk);
    rd_en = 0; ch_event = '0;
  endtask

  task automatic pulse(logic [NCH-1:0] ev);
    @(negedge clk);
    ch_event = ev;
    @(negedge clk);
    ch_event = '0;
    pend_m = pend_m | ({28'd0, ev} & en_m);
  endtask

  function automatic logic irq_exp();
    return (pend_m & mk_m) != 0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 ch_enable after reset", 32'(ch_enable), 32'd0);
    check("R10 irq after reset", 32'(irq), 32'd0);
    rst_n = 1;
    rd('h0C, 4'h0, "R10 enable word after reset");
    rd('h18, 4'h0, "R10 mask word after reset");
    rd('h1C, 4'h0, "R10 pending word after reset");

    wr('h04, 32'h5);
    check("R1 ch_enable after set", 32'(ch_enable), 32'h5);
    rd('h0C, 4'h0, "R3 enable readback");
    wr('h04, 32'hFFFF_FFF2);
    rd('h0C, 4'h0, "R12 upper set bits dropped");
    wr('h08, 32'h1);
    rd('h0C, 4'h0, "R2 clear one channel");
    wr('h08, 32'h0);
    rd('h0C, 4'h0, "R2 zero clear no effect");
    wr('h0C, 32'hF);
    rd('h0C, 4'h0, "R11 write to read-only ignored");
    check("R1 ch_enable output", 32'(ch_enable), en_m);

    wr('h10, 32'hFFFF_FFF3);
    rd('h18, 4'h0, "R4 mask set");
    wr('h14, 32'h1);
    rd('h18, 4'h0, "R4 mask clear");

    pulse(4'hF);
    check("R9 irq with masked pending", 32'(irq), 32'(irq_exp()));
    rd('h1C, 4'h0, "R6 R7 pending enabled only");
    check("R9 irq after acknowledge", 32'(irq), 32'(irq_exp()));
    rd('h1C, 4'h0, "R5 pending cleared by read");

    wr('h14, 32'hF);
    pulse(4'h4);
    check("R9 irq low with zero mask", 32'(irq), 32'd0);
    rd('h1C, 4'h4, "R8 read with coincident event");
    rd('h1C, 4'h0, "R8 coincident event kept");
    wr('h10, 32'h4);
    pulse(4'h9);
    rd('h1C, 4'h0, "R7 disabled channels ignored");
    pulse(4'h4);
    check("R9 irq high", 32'(irq), 32'd1);
    rd('h200, 4'h0, "R11 channel bank reads zero");
    rd('h1C, 4'h0, "R5 pending read");
    check("R9 irq cleared", 32'(irq), 32'd0);

    repeat (3) @(negedge clk);
    check("R11 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule